// File: doc/BRIEF.md
# Queue Fill-Level Watermark Interrupt Generator

This block watches the fill levels of two queues, a receive queue and a command queue, and turns them into interrupt requests. The receive queue raises its watermark request while it holds more entries than a threshold. The command queue raises its request while it holds fewer entries than its threshold. Each threshold is picked by a small coded selector whose codes map onto a fixed, non-uniform list of entry counts.

Each queue also reports overflow pulses. An overflow sets a sticky bit, which holds until a write-one-to-clear strobe clears it. The watermark state bits carry no history and follow their compare result on every cycle. Every request output is its state bit gated by a per-interrupt enable. The flush strobes for the queues pass through as single-cycle pulses, and the readback value of the flush field is always zero.

Top module: `fifo_wmark_irq`

## Requirements
- R1: The receive selector (3 bits) maps code 0→1, 1→4, 2→8, 3→16, 4→30 entries, and codes 5, 6 and 7 map to 30 entries.
- R2: The command selector (2 bits) maps code 0→1, 1→4, 2→8, 3→16 entries.
- R3: The receive watermark state bit is 1 one clock after the receive level is strictly greater than the selected threshold, and 0 otherwise.
- R4: The command watermark state bit is 1 one clock after the command level is strictly less than the selected threshold, and 0 otherwise.
- R5: An overflow pulse sets the matching sticky overflow state bit on the next clock. The bit stays set until a clear strobe arrives.
- R6: A clear strobe with a 1 in state bit position k clears sticky overflow bit k. A set and a clear in the same cycle leave the bit set. Clear strobes have no effect on the watermark bits.
- R7: Each request output equals its state bit AND its enable bit. The state/enable bit order is 0 = receive watermark, 1 = command watermark, 2 = receive overflow, 3 = command overflow.
- R8: The flush outputs are the flush-write strobes gated by the write-valid input, one cycle wide and combinational. The flush readback field is always 0.
- R9: After reset all state bits are 0, and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 7 | Receive queue fill level |
| cmd_level | input | 7 | Command queue fill level |
| rx_sel | input | 3 | Receive threshold code |
| cmd_sel | input | 2 | Command threshold code |
| ovf_pulse | input | 2 | Overflow pulses: bit0 receive, bit1 command |
| clr_wr | input | 4 | Write-one-to-clear strobe over the state bits |
| flush_wr | input | 2 | Flush request bits: bit0 receive, bit1 command |
| flush_wr_vld | input | 1 | Write valid for flush_wr |
| irq_en | input | 4 | Per-interrupt enable |
| irq_state | output | 4 | Interrupt state bits |
| irq_req | output | 4 | Gated interrupt requests |
| flush_out | output | 2 | Flush pulses to the queues |
| flush_rdback | output | 2 | Readback of the flush field (always 0) |

## Verification
On every cycle, the embedded assertions check three things: the watermark state bits against the registered compare result of the levels, the stickiness and clear rules of the overflow bits, and the gating of each request by its enable. The exact threshold value behind each selector code can only be shown by the bench's scenarios. The scenarios sweep levels across each boundary and reach the reserved receive codes. They also cover the simultaneous set-and-clear case.

// File: rtl/fifo_wmark_pkg.sv
package fifo_wmark_pkg;
   localparam int unsigned LVL_W     = 7;
   localparam int unsigned RX_SEL_W  = 3;
   localparam int unsigned CMD_SEL_W = 2;
   localparam int unsigned NUM_IRQ   = 4;
   localparam int unsigned NUM_Q     = 2;

   typedef enum logic [1:0] {
      IRQ_RX_WM   = 2'd0,
      IRQ_CMD_WM  = 2'd1,
      IRQ_RX_OVF  = 2'd2,
      IRQ_CMD_OVF = 2'd3
   } irq_idx_e;

   typedef enum logic [0:0] {
      CMP_ABOVE = 1'b0,
      CMP_BELOW = 1'b1
   } cmp_dir_e;

   function automatic logic [LVL_W-1:0] rx_thresh(input logic [RX_SEL_W-1:0] code);
      case (code)
         3'd0:    return LVL_W'(1);
         3'd1:    return LVL_W'(4);
         3'd2:    return LVL_W'(8);
         3'd3:    return LVL_W'(16);
         default: return LVL_W'(30);
      endcase
   endfunction

   function automatic logic [LVL_W-1:0] cmd_thresh(input logic [CMD_SEL_W-1:0] code);
      case (code)
         2'd0:    return LVL_W'(1);
         2'd1:    return LVL_W'(4);
         2'd2:    return LVL_W'(8);
         default: return LVL_W'(16);
      endcase
   endfunction
endpackage

// File: rtl/wm_compare.sv
module wm_compare
   import fifo_wmark_pkg::*;
#(
   parameter int unsigned  LW  = 7,
   parameter int unsigned  SW  = 3,
   parameter cmp_dir_e     DIR = CMP_ABOVE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] level,
   input  logic [SW-1:0] sel,
   output logic          wm_q
);
   logic [LW-1:0] thr;
   logic          hit;

   initial begin
      assert (LW == LVL_W) else $error("wm_compare: level width mismatch");
      assert (SW >= 1 && SW <= 3) else $error("wm_compare: bad selector width");
   end

   generate
      if (DIR == CMP_ABOVE) begin : g_above
         always_comb thr = rx_thresh(RX_SEL_W'(sel));
         assign hit = (level > thr);
      end else begin : g_below
         always_comb thr = cmd_thresh(CMD_SEL_W'(sel));
         assign hit = (level < thr);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wm_q <= 1'b0;
      else        wm_q <= hit;
   end

   // R3 / R4: the state bit tracks the previous cycle's comparison
   a_r3_wm_follow: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (wm_q == $past(hit)));
endmodule

// File: rtl/ovf_sticky.sv
module ovf_sticky #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_p,
   input  logic [N-1:0] clr_p,
   output logic [N-1:0] st_q
);
   initial assert (N >= 1) else $error("ovf_sticky: N must be positive");

   for (genvar i = 0; i < int'(N); i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        st_q[i] <= 1'b0;
         else if (set_p[i]) st_q[i] <= 1'b1;
         else if (clr_p[i]) st_q[i] <= 1'b0;
      end

      a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
         set_p[i] |=> st_q[i]);
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q[i] && !clr_p[i]) |=> st_q[i]);
      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_p[i] && !set_p[i]) |=> !st_q[i]);
   end
endmodule

// File: rtl/fifo_wmark_irq.sv
module fifo_wmark_irq
   import fifo_wmark_pkg::*;
#(
   parameter int unsigned LW = LVL_W,
   parameter int unsigned NI = NUM_IRQ,
   parameter int unsigned NQ = NUM_Q
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LW-1:0]        rx_level,
   input  logic [LW-1:0]        cmd_level,
   input  logic [RX_SEL_W-1:0]  rx_sel,
   input  logic [CMD_SEL_W-1:0] cmd_sel,
   input  logic [NQ-1:0]        ovf_pulse,
   input  logic [NI-1:0]        clr_wr,
   input  logic [NQ-1:0]        flush_wr,
   input  logic                 flush_wr_vld,
   input  logic [NI-1:0]        irq_en,
   output logic [NI-1:0]        irq_state,
   output logic [NI-1:0]        irq_req,
   output logic [NQ-1:0]        flush_out,
   output logic [NQ-1:0]        flush_rdback
);
   localparam int unsigned OVF_BASE = NQ;

   initial begin
      assert (NI == 2*NQ) else $error("fifo_wmark_irq: NI must be 2*NQ");
      assert (NQ == 2) else $error("fifo_wmark_irq: two queues expected");
   end

   logic rx_wm, cmd_wm;
   logic [NQ-1:0] ovf_st;

   wm_compare #(.LW(LW), .SW(RX_SEL_W), .DIR(CMP_ABOVE)) u_rx_cmp (
      .clk(clk), .rst_n(rst_n), .level(rx_level), .sel(rx_sel), .wm_q(rx_wm));

   wm_compare #(.LW(LW), .SW(CMD_SEL_W), .DIR(CMP_BELOW)) u_cmd_cmp (
      .clk(clk), .rst_n(rst_n), .level(cmd_level), .sel(cmd_sel), .wm_q(cmd_wm));

   ovf_sticky #(.N(NQ)) u_ovf (
      .clk(clk), .rst_n(rst_n), .set_p(ovf_pulse),
      .clr_p(clr_wr[OVF_BASE +: NQ]), .st_q(ovf_st));

   always_comb begin
      irq_state = '0;
      irq_state[IRQ_RX_WM]  = rx_wm;
      irq_state[IRQ_CMD_WM] = cmd_wm;
      irq_state[OVF_BASE +: NQ] = ovf_st;
   end

   assign irq_req      = irq_state & irq_en;
   assign flush_out    = flush_wr & {NQ{flush_wr_vld}};
   assign flush_rdback = '0;

   for (genvar k = 0; k < int'(NI); k++) begin : g_gate
      a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_en[k] |-> !irq_req[k]);
   end
   a_r8_flush_width: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_wr_vld |-> (flush_out == '0));
   a_r6_wm_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level > LW'(30)) |=> irq_state[IRQ_RX_WM]);
endmodule

// File: tb/tb_fifo_wmark_irq.sv
module tb_fifo_wmark_irq;
   logic clk = 0, rst_n = 0;
   logic [6:0] rx_level = 0, cmd_level = 0;
   logic [2:0] rx_sel = 0;
   logic [1:0] cmd_sel = 0, ovf_pulse = 0, flush_wr = 0;
   logic [3:0] clr_wr = 0, irq_en = 0;
   logic flush_wr_vld = 0;
   logic [3:0] irq_state, irq_req;
   logic [1:0] flush_out, flush_rdback;
   int n_tests = 0, n_fail = 0;

   always #5 clk = ~clk;

   fifo_wmark_irq dut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   function automatic int rx_t(int c);
      return c == 0 ? 1 : c == 1 ? 4 : c == 2 ? 8 : c == 3 ? 16 : 30;
   endfunction
   function automatic int cmd_t(int c);
      return c == 0 ? 1 : c == 1 ? 4 : c == 2 ? 8 : 16;
   endfunction

   task automatic t_reset();
      irq_en = 4'hF;
      #2;
      chk("R9 state", irq_state, 0);
      chk("R9 req", irq_req, 0);
   endtask

   task automatic t_rx_thresholds();   // R1 R3
      for (int c = 0; c < 8; c++) begin
         rx_sel = 3'(c);
         rx_level = 7'(rx_t(c)); step();
         chk("R1 R3 at threshold", irq_state[0], 0);
         rx_level = 7'(rx_t(c) + 1); step();
         chk("R1 R3 above threshold", irq_state[0], 1);
      end
      rx_level = 0; step();
      chk("R3 empty", irq_state[0], 0);
   endtask

   task automatic t_cmd_thresholds();  // R2 R4
      for (int c = 0; c < 4; c++) begin
         cmd_sel = 2'(c);
         cmd_level = 7'(cmd_t(c)); step();
         chk("R2 R4 at threshold", irq_state[1], 0);
         cmd_level = 7'(cmd_t(c) - 1); step();
         chk("R2 R4 below threshold", irq_state[1], 1);
      end
      cmd_level = 7'd64; step();
      chk("R4 full", irq_state[1], 0);
   endtask

   task automatic t_overflow();        // R5 R6
      ovf_pulse = 2'b01; step(); ovf_pulse = 0;
      chk("R5 rx ovf set", irq_state[3:2], 2'b01);
      step(); step();
      chk("R5 sticky", irq_state[3:2], 2'b01);
      ovf_pulse = 2'b10; step(); ovf_pulse = 0;
      chk("R5 cmd ovf set", irq_state[3:2], 2'b11);
      clr_wr = 4'b0100; step(); clr_wr = 0;
      chk("R6 clear rx ovf", irq_state[3:2], 2'b10);
      ovf_pulse = 2'b10; clr_wr = 4'b1000; step(); ovf_pulse = 0; clr_wr = 0;
      chk("R6 set wins", irq_state[3:2], 2'b10);
      clr_wr = 4'b1000; step(); clr_wr = 0;
      chk("R6 clear cmd ovf", irq_state[3:2], 2'b00);
      rx_sel = 0; rx_level = 7'd5; cmd_level = 0; step();
      clr_wr = 4'b0011; step(); clr_wr = 0;
      chk("R6 wm unaffected", irq_state[1:0], 2'b11);
   endtask

   task automatic t_enable();          // R7
      irq_en = 4'b0001; #1;
      chk("R7 gated", irq_req, 4'b0001);
      irq_en = 4'b0010; #1;
      chk("R7 gated cmd", irq_req, 4'b0010);
      irq_en = 4'b0000; #1;
      chk("R7 all off", irq_req, 0);
      irq_en = 4'hF;
   endtask

   task automatic t_flush();           // R8
      flush_wr = 2'b11; flush_wr_vld = 0; #1;
      chk("R8 no valid", flush_out, 0);
      flush_wr_vld = 1; #1;
      chk("R8 pulse", flush_out, 2'b11);
      chk("R8 readback", flush_rdback, 0);
      step(); flush_wr = 0; flush_wr_vld = 0; #1;
      chk("R8 single cycle", flush_out, 0);
   endtask

   initial begin
      #20000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      #20 rst_n = 1;
      step();
      t_rx_thresholds();
      t_cmd_thresholds();
      t_overflow();
      t_enable();
      t_flush();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule